// File: doc/BRIEF.md
# Pixel Output Formatter with Blanking

This block sits between the pixel datapath and the device output pins. Raw pixel codes arrive together with four control strobes: a sample strobe that marks a real pixel, a data-clock strobe that advances the output pipeline, a clamp-window strobe and a pre-blank strobe. Each strobe passes through its own programmable polarity. The pixel code and the strobe states for that pixel then move together through a fixed pipeline. At the output end, a pre-blanked pixel is replaced by zero or by the programmed clamp level. A pixel inside the clamp window is never blanked.

After blanking, the word can be converted to Gray code. It then reaches the pins either through an output register loaded on active data-clock cycles or through a transparent path that bypasses that register. An output-enable models a three-state driver. When the driver is disabled, the data bus reads zero.

The block runs on one system clock with a synchronous active-high reset. The data-clock strobe is a qualifier, not a separate clock. All widths and the pipeline depth are parameters. The defaults are a 10-bit bus, an 8-bit clamp level and a latency of 9.

Top module: `pixout_fmt`

## Requirements
- R1: While reset is high and on the first cycle after it, `pix_out` is 0 and `pix_vld` is 0.
- R2: Each strobe input has its own polarity bit. When the bit is 1 the strobe is active while the input is high. When the bit is 0 the strobe is active while the input is low.
- R3: The pipeline and the output register change only on cycles where the data-clock strobe is active. On other cycles, in registered mode, `pix_out` and `pix_vld` hold.
- R4: In registered mode (`cfg_xparent`=0), a pixel presented on an active data-clock cycle appears on `pix_out` after the 9th active data-clock edge, counting the edge that captured it.
- R5: In transparent mode (`cfg_xparent`=1), the output register is bypassed. The pixel appears after the 8th active edge and follows the configuration combinationally.
- R6: A pixel that was pre-blanked, and not in the clamp window, is output as 0 when `cfg_blank_lvl`=0.
- R7: A pixel that was pre-blanked, and not in the clamp window, is output as the clamp level when `cfg_blank_lvl`=1. The clamp level is counted in 1/2^(12-DW) LSB steps, so the output is `cfg_clamp_lvl >> (12-DW)`. With DW=10 this is a shift by 2.
- R8: When the clamp-window strobe and the pre-blank strobe are both active for the same pixel, blanking has no effect and the pixel code passes unchanged.
- R9: With `cfg_gray`=1 the output is the Gray code b ^ (b>>1) of the word after blanking, so blank zeros stay 0.
- R10: `pix_oe` equals the inverse of `cfg_hiz`. While `cfg_hiz`=1, `pix_out` reads 0.
- R11: `pix_vld` carries the sample-strobe state of each pixel with the same latency as its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | DW | Raw pixel code |
| smp_in | input | 1 | Sample strobe, raw |
| dclk_in | input | 1 | Data-clock strobe, raw |
| clamp_in | input | 1 | Clamp-window strobe, raw |
| blank_in | input | 1 | Pre-blank strobe, raw |
| cfg_pol_smp | input | 1 | Sample polarity, 1 = active high |
| cfg_pol_dclk | input | 1 | Data-clock polarity, 1 = active high |
| cfg_pol_clamp | input | 1 | Clamp polarity, 1 = active high |
| cfg_pol_blank | input | 1 | Pre-blank polarity, 1 = active high |
| cfg_blank_lvl | input | 1 | Blank value: 0 = zero, 1 = clamp level |
| cfg_gray | input | 1 | 1 = Gray-coded output |
| cfg_xparent | input | 1 | 1 = transparent output path |
| cfg_hiz | input | 1 | 1 = output driver disabled |
| cfg_clamp_lvl | input | CLW | Clamp level |
| pix_out | output | DW | Output pixel word |
| pix_vld | output | 1 | Output pixel valid |
| pix_oe | output | 1 | Output driver enable |

## Verification
The assertions check four things on every cycle:
- in registered mode, the output holds through stalled data-clock cycles;
- a disabled driver gives a zero bus;
- a blanked pixel at the pipeline tail becomes zero or the scaled clamp level on the next advance;
- a pixel in the clamp window reaches the output unchanged even when it is also blanked.

Only the bench scenarios can show the end-to-end count of nine advances, the one-advance-shorter transparent path, inverted strobe polarities, the Gray coding of blanked words and the valid flag following the sample strobe. The bench shows these by comparing against a queue model on every clock.

// File: rtl/pixout_pkg.sv
package pixout_pkg;
  // Strobe slots in the packed strobe vector.
  typedef enum int {
    STB_SMP   = 0,
    STB_DCLK  = 1,
    STB_CLAMP = 2,
    STB_BLANK = 3
  } stb_idx_e;

  localparam int NUM_STB = 4;
  // Reference resolution in which the clamp level is expressed.
  localparam int LVL_REF_BITS = 12;
endpackage

// File: rtl/pixout_pol.sv
module pixout_pol (
  input  logic raw,
  input  logic pol_hi,
  output logic act
);
  // Active-high strobe passes straight through; active-low is inverted.
  assign act = pol_hi ? raw : ~raw;
endmodule

// File: rtl/pixout_dly.sv
module pixout_dly #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_sr
      logic [W-1:0] sr [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else if (en) begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/pixout_shape.sv
module pixout_shape #(
  parameter int DW  = 10,
  parameter int CLW = 8,
  parameter int SH  = 2
) (
  input  logic [DW-1:0]  data,
  input  logic           blank,
  input  logic           clamp,
  input  logic           lvl_sel,
  input  logic           gray_en,
  input  logic [CLW-1:0] lvl,
  output logic [DW-1:0]  y
);
  logic [CLW-1:0] lvl_sh;
  logic [DW-1:0]  lvl_dw;
  logic [DW-1:0]  blanked;

  assign lvl_sh = lvl >> SH;
  assign lvl_dw = DW'(lvl_sh);

  // The clamp window overrides pre-blanking.
  always_comb begin
    if (blank && !clamp) blanked = lvl_sel ? lvl_dw : '0;
    else                 blanked = data;
  end

  assign y = gray_en ? (blanked ^ (blanked >> 1)) : blanked;
endmodule

// File: rtl/pixout_fmt.sv
module pixout_fmt
  import pixout_pkg::*;
#(
  parameter int DW  = 10,
  parameter int CLW = 8,
  parameter int LAT = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  pix_in,
  input  logic           smp_in,
  input  logic           dclk_in,
  input  logic           clamp_in,
  input  logic           blank_in,
  input  logic           cfg_pol_smp,
  input  logic           cfg_pol_dclk,
  input  logic           cfg_pol_clamp,
  input  logic           cfg_pol_blank,
  input  logic           cfg_blank_lvl,
  input  logic           cfg_gray,
  input  logic           cfg_xparent,
  input  logic           cfg_hiz,
  input  logic [CLW-1:0] cfg_clamp_lvl,
  output logic [DW-1:0]  pix_out,
  output logic           pix_vld,
  output logic           pix_oe
);
  localparam int EW    = DW + 3;
  localparam int DEPTH = LAT - 1;
  localparam int SH    = (DW >= LVL_REF_BITS) ? 0 : (LVL_REF_BITS - DW);

  logic [NUM_STB-1:0] stb_raw, stb_pol, stb_act;
  logic               adv;
  logic [EW-1:0]      ent_in, ent_tail;
  logic [DW-1:0]      tail_data, fmt_y, out_q, sel_data;
  logic               tail_vld, tail_blank, tail_clamp, vld_q, sel_vld;

  always_comb begin
    stb_raw[STB_SMP]   = smp_in;
    stb_raw[STB_DCLK]  = dclk_in;
    stb_raw[STB_CLAMP] = clamp_in;
    stb_raw[STB_BLANK] = blank_in;
    stb_pol[STB_SMP]   = cfg_pol_smp;
    stb_pol[STB_DCLK]  = cfg_pol_dclk;
    stb_pol[STB_CLAMP] = cfg_pol_clamp;
    stb_pol[STB_BLANK] = cfg_pol_blank;
  end

  generate
    for (genvar i = 0; i < NUM_STB; i++) begin : g_pol
      pixout_pol u_pol (.raw(stb_raw[i]), .pol_hi(stb_pol[i]), .act(stb_act[i]));
    end
  endgenerate

  assign adv    = stb_act[STB_DCLK];
  assign ent_in = {stb_act[STB_SMP], stb_act[STB_BLANK], stb_act[STB_CLAMP], pix_in};

  pixout_dly #(.W(EW), .DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst(rst), .en(adv), .d(ent_in), .q(ent_tail)
  );

  assign tail_data  = ent_tail[DW-1:0];
  assign tail_clamp = ent_tail[DW];
  assign tail_blank = ent_tail[DW+1];
  assign tail_vld   = ent_tail[DW+2];

  pixout_shape #(.DW(DW), .CLW(CLW), .SH(SH)) u_shape (
    .data(tail_data), .blank(tail_blank), .clamp(tail_clamp),
    .lvl_sel(cfg_blank_lvl), .gray_en(cfg_gray), .lvl(cfg_clamp_lvl), .y(fmt_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else if (adv) begin
      out_q <= fmt_y;
      vld_q <= tail_vld;
    end
  end

  assign sel_data = cfg_xparent ? fmt_y : out_q;
  assign sel_vld  = cfg_xparent ? tail_vld : vld_q;
  assign pix_out  = cfg_hiz ? '0 : sel_data;
  assign pix_vld  = sel_vld;
  assign pix_oe   = ~cfg_hiz;
endmodule

// File: rtl/pixout_fmt_chk.sv
module pixout_fmt_chk #(
  parameter int DW  = 10,
  parameter int CLW = 8,
  parameter int SH  = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           adv,
  input logic           xp,
  input logic           hiz,
  input logic           gray,
  input logic           blank_lvl,
  input logic [CLW-1:0] lvl,
  input logic           tail_blank,
  input logic           tail_clamp,
  input logic [DW-1:0]  tail_data,
  input logic [DW-1:0]  pix_out,
  input logic           pix_vld,
  input logic           pix_oe
);
  logic [DW-1:0] lvl_dw;
  assign lvl_dw = DW'(lvl >> SH);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(adv) && !xp && !$past(xp) && !hiz && !$past(hiz))
      |-> ($stable(pix_out) && $stable(pix_vld)));

  p_blank_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && !xp && tail_blank && !tail_clamp && !blank_lvl)
      |=> (hiz || xp || pix_out == '0));

  p_blank_level_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && !xp && !gray && tail_blank && !tail_clamp && blank_lvl)
      |=> (hiz || xp || gray || pix_out == $past(lvl_dw)));

  p_clamp_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && !xp && !gray && tail_clamp)
      |=> (hiz || xp || gray || pix_out == $past(tail_data)));

  p_hiz_r10: assert property (@(posedge clk) disable iff (rst)
    hiz |-> (pix_out == '0 && !pix_oe));
endmodule

bind pixout_fmt pixout_fmt_chk #(.DW(DW), .CLW(CLW), .SH(SH)) u_chk (
  .clk(clk), .rst(rst), .adv(adv), .xp(cfg_xparent), .hiz(cfg_hiz),
  .gray(cfg_gray), .blank_lvl(cfg_blank_lvl), .lvl(cfg_clamp_lvl),
  .tail_blank(tail_blank), .tail_clamp(tail_clamp), .tail_data(tail_data),
  .pix_out(pix_out), .pix_vld(pix_vld), .pix_oe(pix_oe)
);

// File: tb/pixout_fmt_tb.sv
module pixout_fmt_tb;
  localparam int DW  = 10;
  localparam int CLW = 8;
  localparam int LAT = 9;

  logic clk = 0, rst = 1;
  logic [DW-1:0] pix_in = '0;
  logic smp_in = 0, dclk_in = 0, clamp_in = 0, blank_in = 0;
  logic pol_smp = 1, pol_dclk = 1, pol_clamp = 1, pol_blank = 1;
  logic blank_lvl = 0, gray = 0, xp = 0, hiz = 0;
  logic [CLW-1:0] lvl = '0;
  logic [DW-1:0] pix_out;
  logic pix_vld, pix_oe;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  pixout_fmt #(.DW(DW), .CLW(CLW), .LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .pix_in(pix_in), .smp_in(smp_in), .dclk_in(dclk_in),
    .clamp_in(clamp_in), .blank_in(blank_in), .cfg_pol_smp(pol_smp),
    .cfg_pol_dclk(pol_dclk), .cfg_pol_clamp(pol_clamp), .cfg_pol_blank(pol_blank),
    .cfg_blank_lvl(blank_lvl), .cfg_gray(gray), .cfg_xparent(xp), .cfg_hiz(hiz),
    .cfg_clamp_lvl(lvl), .pix_out(pix_out), .pix_vld(pix_vld), .pix_oe(pix_oe)
  );

  // Behavioural reference: queues of pixel entries, one push per advance.
  int qd[$], qv[$], qb[$], qc[$];
  int md = 0, mv = 0;

  function automatic int fmt(int d, int b, int c);
    int r;
    if (b != 0 && c == 0) r = blank_lvl ? (int'(lvl) >> (12 - DW)) : 0;
    else r = d;
    if (gray) r = r ^ (r >> 1);
    return r;
  endfunction

  function automatic bit act(logic raw, logic pol);
    return pol ? raw : !raw;
  endfunction

  task automatic chk(int got, int exp, string what);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    int ed, ev;
    if (rst) begin
      qd = {}; qv = {}; qb = {}; qc = {};
      for (int i = 0; i < LAT - 1; i++) begin
        qd.push_back(0); qv.push_back(0); qb.push_back(0); qc.push_back(0);
      end
      md = 0; mv = 0;
    end else if (act(dclk_in, pol_dclk)) begin
      md = fmt(qd[0], qb[0], qc[0]);
      mv = qv[0];
      qd.push_back(int'(pix_in)); qv.push_back(int'(act(smp_in, pol_smp)));
      qb.push_back(int'(act(blank_in, pol_blank))); qc.push_back(int'(act(clamp_in, pol_clamp)));
      void'(qd.pop_front()); void'(qv.pop_front());
      void'(qb.pop_front()); void'(qc.pop_front());
    end
    #2;
    ed = xp ? fmt(qd[0], qb[0], qc[0]) : md;
    ev = xp ? qv[0] : mv;
    if (hiz) ed = 0;
    chk(int'(pix_out), ed, "pix_out");
    chk(int'(pix_vld), ev, "pix_vld");
    chk(int'(pix_oe), int'(!hiz), "pix_oe");
  end

  // Drive one cycle with active-level strobes, converted to raw per polarity.
  task automatic step(int d, bit s, bit dc, bit c, bit b);
    @(negedge clk);
    pix_in   = DW'(d);
    smp_in   = pol_smp   ? s  : !s;
    dclk_in  = pol_dclk  ? dc : !dc;
    clamp_in = pol_clamp ? c  : !c;
    blank_in = pol_blank ? b  : !b;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
    @(negedge clk); rst = 0;
    step(5, 1, 1, 0, 0);
    // R4 and R11: continuous advance, sample strobe with gaps
    cur_req = "R4";
    for (int i = 0; i < 30; i++) step(i * 7 + 3, (i % 4) != 2, 1, 0, 0);
    cur_req = "R11";
    for (int i = 0; i < 12; i++) step(900 - i, i[0], 1, 0, 0);
    // R3: data-clock active only some cycles
    cur_req = "R3";
    for (int i = 0; i < 40; i++) step(i * 13, 1, (i % 3) != 0, 0, 0);
    // R2: all strobes active low
    cur_req = "R2";
    @(negedge clk); pol_smp = 0; pol_dclk = 0; pol_clamp = 0; pol_blank = 0;
    for (int i = 0; i < 30; i++) step(i * 11 + 1, (i % 5) != 0, (i % 4) != 1, 0, (i % 6) == 3);
    @(negedge clk); pol_smp = 1; pol_dclk = 1; pol_clamp = 1; pol_blank = 1;
    // R6: blank to zero
    cur_req = "R6";
    for (int i = 0; i < 24; i++) step(500 + i, 1, 1, 0, (i >= 4 && i < 14));
    // R7: blank to clamp level (0xB7 >> 2 = 45)
    cur_req = "R7";
    @(negedge clk); blank_lvl = 1; lvl = 8'hB7;
    for (int i = 0; i < 24; i++) step(300 + i, 1, 1, 0, (i >= 2 && i < 12));
    // R8: clamp overlapping blanking
    cur_req = "R8";
    for (int i = 0; i < 24; i++) step(700 + i, 1, 1, (i >= 5 && i < 10), (i < 15));
    @(negedge clk); blank_lvl = 0;
    // R9: Gray output including blanked zeros
    cur_req = "R9";
    @(negedge clk); gray = 1;
    for (int i = 0; i < 24; i++) step(i * 37 + 2, 1, 1, 0, (i % 5) == 0);
    // R5: transparent path, with and without stalls
    cur_req = "R5";
    @(negedge clk); xp = 1;
    for (int i = 0; i < 30; i++) step(i * 29, 1, (i % 4) != 3, 0, (i % 7) == 2);
    @(negedge clk); gray = 0;
    for (int i = 0; i < 10; i++) step(i * 3, 1, 1, 0, 0);
    @(negedge clk); xp = 0;
    // R10: driver disabled then re-enabled
    cur_req = "R10";
    @(negedge clk); hiz = 1;
    for (int i = 0; i < 14; i++) step(1000 - i * 9, 1, 1, 0, 0);
    @(negedge clk); hiz = 0;
    for (int i = 0; i < 14; i++) step(i * 17, 1, 1, 0, 0);
    // R1: reset in mid-stream clears outputs
    cur_req = "R1";
    @(negedge clk); rst = 1;
    for (int i = 0; i < 3; i++) step(77, 1, 1, 0, 0);
    @(negedge clk); rst = 0;
    for (int i = 0; i < 12; i++) step(i + 40, 1, 1, 0, 0);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule